// File: doc/BRIEF.md
# Mode-Banked Register File with Exception Entry

This block is the general-purpose register store of a 32-bit RISC core. It holds 31 physical data registers, one current status word and five saved status words: 37 registers of 32 bits in all. At any moment only sixteen logical registers, r0 to r15, are visible, and the current mode field in the status word decides which physical copy each logical number reaches. r13 serves as stack pointer, r14 as link register and r15 as program counter.

Two read ports and one write port are addressed by logical number. A whole-word status write changes the mode. An exception-entry strobe with a 3-bit type and a return address performs a whole mode switch in one clock edge. It saves the status word into the saved slot of the target mode, puts the return address into that mode's own link register, loads the vector into r15 and rewrites the status word. A return strobe reverses the switch: the status word comes back from the saved slot and r15 comes back from the banked link register.

Top module: `banked_regfile`

## Requirements
- R1: After reset the status word reads 0x000000D3 (Supervisor, I=1, F=1, T=0, flags clear), every register reads zero and the saved-status output reads zero.
- R2: Mode codes are User 0x10, FIQ 0x11, IRQ 0x12, Supervisor 0x13, Abort 0x17, Undefined 0x1B and System 0x1F, held in status bits [4:0]. r0..r7 and r15 are shared by all modes. FIQ has private r8..r14. IRQ, Supervisor, Abort and Undefined each have a private r13 and r14. System mode, and any code not in the list, use the User registers.
- R3: Both read ports are combinational, return the physical register that the current mode maps to, and show a write from the following cycle on.
- R4: A register write stores `wr_data` at the clock edge into the register that `wr_idx` maps to in the mode held before that edge.
- R5: A status write loads `cpsr_wr_data` with only bits [31:28] (N, Z, C, V), bit 7 (I), bit 6 (F), bit 5 (T) and bits [4:0] (mode) kept; all other bits read zero.
- R6: On exception entry the type selects the target mode: 0 reset and 2 software call go to Supervisor, 1 undefined goes to Undefined, 3 prefetch abort and 4 data abort go to Abort, 6 goes to IRQ and 7 goes to FIQ. The old status word goes into the target's saved slot, `exc_ret_addr` goes into the target's r14, and r15 becomes base + 4*type, where the base is 0xFFFF0000 when `hi_vec` is 1 and 0 otherwise.
- R7: After entry the status word has the target mode, T=0 and I=1. F is set for types 0 and 7 and kept for all other types. The flags are kept.
- R8: Exception type 5 is reserved. Its strobe has no effect, and any other operation in that cycle proceeds as if no strobe were present.
- R9: A valid exception entry discards a register write, a status write and a return strobe in the same cycle. A return discards a register write and a status write in the same cycle. A register write and a status write in the same cycle both take effect. Without entry, return or status write, the status word holds.
- R10: A return in a mode that has a saved slot loads the status word from that slot and loads r15 from the current mode's r14. In User, System or an unknown mode the return strobe is ignored.
- R11: `spsr_out` shows the saved slot of the current mode, or zero in modes that have none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Logical register for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Logical register for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Logical register to write |
| wr_data | input | 32 | Write data |
| cpsr_wr_en | input | 1 | Status word write strobe |
| cpsr_wr_data | input | 32 | New status word |
| exc_en | input | 1 | Exception entry strobe |
| exc_type | input | 3 | Exception type / vector index |
| exc_ret_addr | input | 32 | Return address for the banked link register |
| hi_vec | input | 1 | Selects the high vector base |
| ret_en | input | 1 | Exception return strobe |
| cpsr_out | output | 32 | Current status word |
| spsr_out | output | 32 | Saved status of the current mode |

## Verification
A wrong bank mapping stays hidden until the mode changes. It shows as a read port returning another mode's r8..r14 on the first read of that register after a mode switch. A lost or misplaced saved status word or link register shows only at the next return, as a wrong `cpsr_out` and a wrong r15 one cycle after the strobe. For that reason the stimulus nests entries, returns and mode writes over many modes, and it compares both read ports and both status outputs against a behavioural model after every clock edge.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int XLEN     = 32;
  localparam int NLOG     = 16;
  localparam int LIDX_W   = $clog2(NLOG);
  localparam int NPHYS    = 31;
  localparam int PIDX_W   = $clog2(NPHYS + 1);
  localparam int NSAVED   = 5;
  localparam int SLOT_W   = $clog2(NSAVED);

  localparam logic [4:0] MODE_USR = 5'h10;
  localparam logic [4:0] MODE_FIQ = 5'h11;
  localparam logic [4:0] MODE_IRQ = 5'h12;
  localparam logic [4:0] MODE_SVC = 5'h13;
  localparam logic [4:0] MODE_ABT = 5'h17;
  localparam logic [4:0] MODE_UND = 5'h1B;
  localparam logic [4:0] MODE_SYS = 5'h1F;

  localparam logic [XLEN-1:0] PSR_KEEP  = 32'hF00000FF;
  localparam logic [XLEN-1:0] PSR_RESET = 32'h000000D3;
  localparam logic [2:0]      EXC_RSVD  = 3'd5;

  // logical register number -> physical slot in the flat array
  function automatic logic [PIDX_W-1:0] phys_of(input logic [4:0] mode,
                                                input logic [LIDX_W-1:0] r);
    logic [PIDX_W-1:0] base;
    base = {1'b0, r};
    phys_of = base;
    case (mode)
      MODE_FIQ: if (r >= 4'd8 && r <= 4'd14) phys_of = base + 5'd8;
      MODE_IRQ: if (r == 4'd13 || r == 4'd14) phys_of = base + 5'd10;
      MODE_SVC: if (r == 4'd13 || r == 4'd14) phys_of = base + 5'd12;
      MODE_ABT: if (r == 4'd13 || r == 4'd14) phys_of = base + 5'd14;
      MODE_UND: if (r == 4'd13 || r == 4'd14) phys_of = base + 5'd16;
      default:  phys_of = base;
    endcase
  endfunction

  function automatic logic has_saved(input logic [4:0] mode);
    has_saved = (mode == MODE_FIQ) || (mode == MODE_IRQ) || (mode == MODE_SVC) ||
                (mode == MODE_ABT) || (mode == MODE_UND);
  endfunction

  function automatic logic [SLOT_W-1:0] saved_slot(input logic [4:0] mode);
    case (mode)
      MODE_FIQ: saved_slot = 3'd0;
      MODE_IRQ: saved_slot = 3'd1;
      MODE_SVC: saved_slot = 3'd2;
      MODE_ABT: saved_slot = 3'd3;
      default:  saved_slot = 3'd4;
    endcase
  endfunction

  function automatic logic [4:0] exc_target(input logic [2:0] t);
    case (t)
      3'd1:       exc_target = MODE_UND;
      3'd3, 3'd4: exc_target = MODE_ABT;
      3'd6:       exc_target = MODE_IRQ;
      3'd7:       exc_target = MODE_FIQ;
      default:    exc_target = MODE_SVC;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] vec_addr(input logic [2:0] t, input logic hi);
    vec_addr = {(hi ? 16'hFFFF : 16'h0000), 11'd0, t, 2'b00};
  endfunction
endpackage

// File: rtl/bank_map.sv
module bank_map
  import bank_pkg::*;
#(
  parameter int NP = 2
) (
  input  logic [4:0]                  mode,
  input  logic [NP-1:0][LIDX_W-1:0]   lidx,
  output logic [NP-1:0][PIDX_W-1:0]   pidx
);
  for (genvar g = 0; g < NP; g++) begin : g_map
    assign pidx[g] = phys_of(mode, lidx[g]);
  end
endmodule

// File: rtl/gpr_array.sv
module gpr_array #(
  parameter int W     = 32,
  parameter int DEPTH = 31,
  parameter int NRP   = 3,
  parameter int NWP   = 2,
  localparam int AW   = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NRP-1:0][AW-1:0]   raddr,
  output logic [NRP-1:0][W-1:0]    rdata,
  input  logic [NWP-1:0]           we,
  input  logic [NWP-1:0][AW-1:0]   waddr,
  input  logic [NWP-1:0][W-1:0]    wdata
);
  logic [W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else begin
      for (int p = 0; p < NWP; p++)
        if (we[p] && (int'(waddr[p]) < DEPTH)) regs[waddr[p]] <= wdata[p];
    end
  end

  for (genvar g = 0; g < NRP; g++) begin : g_rd
    assign rdata[g] = (int'(raddr[g]) < DEPTH) ? regs[raddr[g]] : '0;
  end
endmodule

// File: rtl/exc_unit.sv
module exc_unit
  import bank_pkg::*;
(
  input  logic [XLEN-1:0] cpsr,
  input  logic [2:0]      etype,
  input  logic            hi,
  output logic            valid,
  output logic [4:0]      tmode,
  output logic [XLEN-1:0] vec,
  output logic [XLEN-1:0] cpsr_nxt
);
  logic fbit;

  always_comb begin
    valid    = (etype != EXC_RSVD);
    tmode    = exc_target(etype);
    vec      = vec_addr(etype, hi);
    fbit     = cpsr[6] | (etype == 3'd0) | (etype == 3'd7);
    cpsr_nxt = {cpsr[31:28], 20'd0, 1'b1, fbit, 1'b0, tmode};
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  rd_a_idx,
  output logic [31:0] rd_a_data,
  input  logic [3:0]  rd_b_idx,
  output logic [31:0] rd_b_data,
  input  logic        wr_en,
  input  logic [3:0]  wr_idx,
  input  logic [31:0] wr_data,
  input  logic        cpsr_wr_en,
  input  logic [31:0] cpsr_wr_data,
  input  logic        exc_en,
  input  logic [2:0]  exc_type,
  input  logic [31:0] exc_ret_addr,
  input  logic        hi_vec,
  input  logic        ret_en,
  output logic [31:0] cpsr_out,
  output logic [31:0] spsr_out
);
  localparam logic [LIDX_W-1:0] R_LR = 4'd14;
  localparam logic [PIDX_W-1:0] P_PC = 5'd15;

  logic [XLEN-1:0] cpsr_q;
  logic [XLEN-1:0] spsr_q [NSAVED];
  logic [4:0]      cur_mode;

  // named events
  logic exc_ok, exc_fire, ret_fire, psr_fire, wr_fire;
  logic [4:0]      tgt_mode;
  logic [XLEN-1:0] vec, cpsr_exc;

  assign cur_mode = cpsr_q[4:0];

  exc_unit u_exc (
    .cpsr(cpsr_q), .etype(exc_type), .hi(hi_vec),
    .valid(exc_ok), .tmode(tgt_mode), .vec(vec), .cpsr_nxt(cpsr_exc)
  );

  assign exc_fire = exc_en & exc_ok;
  assign ret_fire = ret_en & has_saved(cur_mode) & ~exc_fire;
  assign psr_fire = cpsr_wr_en & ~exc_fire & ~ret_fire;
  assign wr_fire  = wr_en & ~exc_fire & ~ret_fire;

  // mapping in current mode: rd_a, rd_b, write, own r14
  logic [3:0][PIDX_W-1:0] cur_p;
  logic [0:0][PIDX_W-1:0] tgt_p;

  bank_map #(.NP(4)) u_map_cur (
    .mode(cur_mode), .lidx({R_LR, wr_idx, rd_b_idx, rd_a_idx}), .pidx(cur_p)
  );
  bank_map #(.NP(1)) u_map_tgt (
    .mode(tgt_mode), .lidx(R_LR), .pidx(tgt_p)
  );

  logic [2:0][PIDX_W-1:0] ra;
  logic [2:0][XLEN-1:0]   rdat;
  logic [1:0]             we;
  logic [1:0][PIDX_W-1:0] wa;
  logic [1:0][XLEN-1:0]   wd;

  assign ra = {cur_p[3], cur_p[1], cur_p[0]};

  always_comb begin
    we[0] = exc_fire | ret_fire | wr_fire;
    wa[0] = (exc_fire | ret_fire) ? P_PC : cur_p[2];
    wd[0] = exc_fire ? vec : (ret_fire ? rdat[2] : wr_data);
    we[1] = exc_fire;
    wa[1] = tgt_p[0];
    wd[1] = exc_ret_addr;
  end

  gpr_array #(.W(XLEN), .DEPTH(NPHYS), .NRP(3), .NWP(2)) u_gpr (
    .clk(clk), .rst_n(rst_n), .raddr(ra), .rdata(rdat),
    .we(we), .waddr(wa), .wdata(wd)
  );

  assign rd_a_data = rdat[0];
  assign rd_b_data = rdat[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpsr_q <= PSR_RESET;
      for (int i = 0; i < NSAVED; i++) spsr_q[i] <= '0;
    end else if (exc_fire) begin
      cpsr_q <= cpsr_exc;
      spsr_q[saved_slot(tgt_mode)] <= cpsr_q;
    end else if (ret_fire) begin
      cpsr_q <= spsr_q[saved_slot(cur_mode)] & PSR_KEEP;
    end else if (psr_fire) begin
      cpsr_q <= cpsr_wr_data & PSR_KEEP;
    end
  end

  assign cpsr_out = cpsr_q;
  assign spsr_out = has_saved(cur_mode) ? spsr_q[saved_slot(cur_mode)] : '0;

  // R7
  exc_ibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_fire |=> (cpsr_out[7] && !cpsr_out[5]));

  // R6
  exc_spsr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_fire |=> (spsr_out == $past(cpsr_out)));

  // R10
  ret_cpsr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire |=> (cpsr_out == $past(spsr_out)));

  // R9
  psr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_fire && !ret_fire && !cpsr_wr_en) |=> $stable(cpsr_out));
endmodule

// File: tb/banked_regfile_tb_top.sv
`timescale 1ns/1ps
module banked_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, cpsr_wr_en = 1'b0, exc_en = 1'b0, hi_vec = 1'b0, ret_en = 1'b0;
  logic [31:0] cpsr_wr_data = '0, exc_ret_addr = '0;
  logic [2:0]  exc_type = '0;
  logic [31:0] cpsr_out, spsr_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  banked_regfile dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cpsr_wr_en(cpsr_wr_en), .cpsr_wr_data(cpsr_wr_data),
    .exc_en(exc_en), .exc_type(exc_type), .exc_ret_addr(exc_ret_addr),
    .hi_vec(hi_vec), .ret_en(ret_en),
    .cpsr_out(cpsr_out), .spsr_out(spsr_out)
  );

  // behavioural model: separate banks per mode
  logic [31:0] m_usr [16];
  logic [31:0] m_fiq [16];
  logic [31:0] m_sp [5];
  logic [31:0] m_lr [5];
  logic [31:0] m_spsr [5];
  logic [31:0] m_cpsr;

  // which bank group a mode code owns: -1 none, 0 fiq, 1..4 others
  function automatic int grp(input logic [4:0] m);
    if (m == 5'h11) return 0;
    if (m == 5'h12) return 1;
    if (m == 5'h13) return 2;
    if (m == 5'h17) return 3;
    if (m == 5'h1B) return 4;
    return -1;
  endfunction

  function automatic logic [31:0] m_get(input logic [4:0] m, input int r);
    int g = grp(m);
    if (g == 0 && r >= 8 && r <= 14) return m_fiq[r];
    if (g > 0 && r == 13) return m_sp[g];
    if (g > 0 && r == 14) return m_lr[g];
    return m_usr[r];
  endfunction

  task automatic m_set(input logic [4:0] m, input int r, input logic [31:0] v);
    int g = grp(m);
    if (g == 0 && r >= 8 && r <= 14) m_fiq[r] = v;
    else if (g > 0 && r == 13) m_sp[g] = v;
    else if (g > 0 && r == 14) m_lr[g] = v;
    else m_usr[r] = v;
  endtask

  task automatic m_reset();
    for (int i = 0; i < 16; i++) begin m_usr[i] = 0; m_fiq[i] = 0; end
    for (int i = 0; i < 5; i++) begin m_sp[i] = 0; m_lr[i] = 0; m_spsr[i] = 0; end
    m_cpsr = 32'hD3;
  endtask

  task automatic m_step();
    logic [4:0] vm = m_cpsr[4:0];
    logic [4:0] tm;
    logic [31:0] pc;
    bit fnew;
    bit took_exc = exc_en && (exc_type != 3'd5);
    bit took_ret = !took_exc && ret_en && (grp(vm) >= 0);
    if (took_exc) begin
      case (exc_type)
        3'd1: tm = 5'h1B;
        3'd3: tm = 5'h17;
        3'd4: tm = 5'h17;
        3'd6: tm = 5'h12;
        3'd7: tm = 5'h11;
        default: tm = 5'h13;
      endcase
      m_spsr[grp(tm)] = m_cpsr;
      m_set(tm, 14, exc_ret_addr);
      m_set(tm, 15, (hi_vec ? 32'hFFFF0000 : 32'h0) + 32'(exc_type) * 4);
      fnew = m_cpsr[6] || exc_type == 3'd0 || exc_type == 3'd7;
      m_cpsr = (m_cpsr & 32'hF0000000) | 32'h80 | (fnew ? 32'h40 : 32'h0) | 32'(tm);
    end else if (took_ret) begin
      pc = m_get(vm, 14);
      m_cpsr = m_spsr[grp(vm)];
      m_set(vm, 15, pc);
    end else begin
      if (wr_en) m_set(vm, int'(wr_idx), wr_data);
      if (cpsr_wr_en) m_cpsr = cpsr_wr_data & 32'hF00000FF;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string ctx);
    logic [31:0] exp_sp;
    exp_sp = (grp(m_cpsr[4:0]) >= 0) ? m_spsr[grp(m_cpsr[4:0])] : 32'h0;
    chk({ctx, " R5 R7 R9 R10 cpsr"}, cpsr_out, m_cpsr);
    chk({ctx, " R6 R8 R11 spsr"}, spsr_out, exp_sp);
    chk({ctx, " R2 R3 R4 R6 rdA"}, rd_a_data, m_get(m_cpsr[4:0], int'(rd_a_idx)));
    chk({ctx, " R2 R3 R4 R6 rdB"}, rd_b_data, m_get(m_cpsr[4:0], int'(rd_b_idx)));
  endtask

  function automatic logic [4:0] pick_mode(input int k);
    case (k)
      0: return 5'h10; 1: return 5'h11; 2: return 5'h12; 3: return 5'h13;
      4: return 5'h17; 5: return 5'h1B; 6: return 5'h1F; default: return 5'h00;
    endcase
  endfunction

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset cpsr", cpsr_out, 32'h000000D3);
    chk("R1 reset spsr", spsr_out, 32'h0);
    for (int r = 0; r < 16; r++) begin
      rd_a_idx = 4'(r);
      #0.1;
      chk("R1 reset reg", rd_a_data, 32'h0);
    end
    for (int cyc = 0; cyc < 6000; cyc++) begin
      int p;
      compare_all("cycle");
      p = $urandom_range(99);
      rd_a_idx     = 4'($urandom_range(15));
      rd_b_idx     = (p < 50) ? 4'($urandom_range(8, 15)) : 4'($urandom_range(15));
      wr_en        = ($urandom_range(99) < 55);
      wr_idx       = 4'($urandom_range(15));
      wr_data      = $urandom;
      cpsr_wr_en   = ($urandom_range(99) < 12);
      cpsr_wr_data = {$urandom} & 32'hFFFFFFE0 | 32'(pick_mode($urandom_range(7)));
      exc_en       = ($urandom_range(99) < 12);
      exc_type     = 3'($urandom_range(7));
      exc_ret_addr = $urandom;
      hi_vec       = $urandom_range(1) == 1;
      ret_en       = ($urandom_range(99) < 10);
      m_step();
      @(negedge clk);
    end
    compare_all("final");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule